// File: doc/BRIEF.md
# Stride-Based Instruction Result Validator

This block sits beside the completion stage of a core that runs a main thread and a trailing redundant copy of the same program for soft-error detection. It holds, for each instruction address, the last result that instruction produced and the difference between its last two results. From these it forms an expected next result as last value plus stride. When a main-thread instruction completes, its address and actual result are presented on the compare port. One cycle later the block returns a verdict. "Validated" means the result matched the expectation, so the redundant copy may be dropped. "Re-execute" means the redundant thread must run the instruction.

The table is direct-mapped and has 4096 entries by default. It is indexed by the address bits just above the instruction-alignment bits and guarded by a partial address tag. An entry is trained on every compare, whatever the verdict. An entry whose learned stride is zero is treated as low confidence and never grants validation. This suppresses predictions that are right only because a value repeats. A single upset that happens to produce exactly the predicted value goes unnoticed, and that risk is accepted.

Top module: `result_validator`

## Requirements
- R1: A synchronous reset invalidates every table entry, so the first compare of any address after reset returns re-execute.
- R2: Each compare presented with `cmp_valid` high at a clock edge produces `verdict_valid` high after that same edge, for exactly one cycle per request. `verdict_valid` is low after an edge with no request and low during reset.
- R3: While `verdict_valid` is high, exactly one of `validated` and `re_execute` is high (1 = re-execute, 0 = dropped). While it is low, both are low.
- R4: A compare whose index holds no valid entry, or holds one with a different tag, returns re-execute. It then allocates the entry with last value = result and stride = 0.
- R5: A compare that hits an entry with nonzero stride and whose result equals last + stride returns validated.
- R6: A compare that hits and whose result differs from last + stride returns re-execute.
- R7: When the hit entry's stride is zero, the verdict is re-execute even if the result equals the last value (the default `GATE_ZERO_STRIDE` = 1).
- R8: Every hit updates the entry: the stride becomes result minus old last value, and the last value becomes the result. This happens for both verdicts.
- R9: The index is `cmp_pc[ALIGN_W +: IDX_W]` and the tag is the next `TAG_W` bits above it. Two addresses with the same index but different tags evict each other.
- R10: Prediction and stride arithmetic wrap modulo 2^`DATA_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Compare request strobe |
| cmp_pc | input | PC_W | Address of the completing instruction |
| cmp_result | input | DATA_W | Actual result value |
| verdict_valid | output | 1 | Verdict for the previous cycle's request |
| validated | output | 1 | Result matched the prediction; the redundant copy may be dropped |
| re_execute | output | 1 | The redundant thread must execute this instruction |

## Verification
The bench builds the validator with 16 entries, a 4-bit tag and 16-bit data rather than the 4096-entry default. With only 16 entries, random addresses drawn from a small pool collide often, which exercises evictions and tag misses (R4, R9) heavily. The 16-bit data path lets the directed cases reach wrap-around in the predicted value (R10) with simple constants. A bench model of the table drives the random phase, and the stream deliberately feeds either the predicted value or a random one so that all four verdict paths occur many times.

// File: rtl/rv_pkg.sv
package rv_pkg;
   typedef enum logic {
      RV_REEXEC = 1'b0,
      RV_DROP   = 1'b1
   } rv_verdict_e;
endpackage

// File: rtl/rv_addr_split.sv
module rv_addr_split #(
   parameter int PC_W    = 32,
   parameter int ALIGN_W = 2,
   parameter int IDX_W   = 12,
   parameter int TAG_W   = 8
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);
   localparam int TAG_LSB = ALIGN_W + IDX_W;

   assign idx = pc[ALIGN_W +: IDX_W];
   assign tag = pc[TAG_LSB +: TAG_W];
endmodule

// File: rtl/rv_table.sv
module rv_table #(
   parameter int IDX_W  = 12,
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_vld,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_last,
   output logic [DATA_W-1:0] rd_stride,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_last,
   input  logic [DATA_W-1:0] wr_stride
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_mem    [DEPTH];
   logic [DATA_W-1:0] last_mem   [DEPTH];
   logic [DATA_W-1:0] stride_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst)
         vld_q <= '0;
      else if (wr_en)
         vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_idx]    <= wr_tag;
         last_mem[wr_idx]   <= wr_last;
         stride_mem[wr_idx] <= wr_stride;
      end
   end

   assign rd_vld    = vld_q[rd_idx];
   assign rd_tag    = tag_mem[rd_idx];
   assign rd_last   = last_mem[rd_idx];
   assign rd_stride = stride_mem[rd_idx];
endmodule

// File: rtl/rv_judge.sv
module rv_judge #(
   parameter int DATA_W           = 32,
   parameter bit GATE_ZERO_STRIDE = 1'b1
) (
   input  logic              hit,
   input  logic [DATA_W-1:0] last,
   input  logic [DATA_W-1:0] stride,
   input  logic [DATA_W-1:0] result,
   output logic              match,
   output logic [DATA_W-1:0] next_stride
);
   logic [DATA_W-1:0] expect_val;
   logic              eq;

   assign expect_val = last + stride;
   assign eq         = (expect_val == result);

   generate
      if (GATE_ZERO_STRIDE) begin : g_gated
         assign match = hit && (stride != '0) && eq;
      end else begin : g_open
         assign match = hit && eq;
      end
   endgenerate

   assign next_stride = hit ? (result - last) : '0;
endmodule

// File: rtl/result_validator.sv
module result_validator #(
   parameter int PC_W             = 32,
   parameter int DATA_W           = 32,
   parameter int ALIGN_W          = 2,
   parameter int IDX_W            = 12,
   parameter int TAG_W            = 8,
   parameter bit GATE_ZERO_STRIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmp_valid,
   input  logic [PC_W-1:0]   cmp_pc,
   input  logic [DATA_W-1:0] cmp_result,
   output logic              verdict_valid,
   output logic              validated,
   output logic              re_execute
);
   import rv_pkg::*;

   localparam int USED_PC_BITS = ALIGN_W + IDX_W + TAG_W;

   generate
      if (USED_PC_BITS > PC_W) begin : g_bad_split
         $error("result_validator: ALIGN_W+IDX_W+TAG_W exceeds PC_W");
      end
      if (IDX_W < 1 || TAG_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("result_validator: widths must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   logic              ent_vld;
   logic [TAG_W-1:0]  ent_tag;
   logic [DATA_W-1:0] ent_last;
   logic [DATA_W-1:0] ent_stride;
   logic              hit;
   logic              match;
   logic [DATA_W-1:0] new_stride;

   rv_addr_split #(
      .PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
   ) u_split (
      .pc(cmp_pc), .idx(idx), .tag(tag)
   );

   rv_table #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) u_table (
      .clk(clk), .rst(rst),
      .rd_idx(idx), .rd_vld(ent_vld), .rd_tag(ent_tag),
      .rd_last(ent_last), .rd_stride(ent_stride),
      .wr_en(cmp_valid), .wr_idx(idx), .wr_tag(tag),
      .wr_last(cmp_result), .wr_stride(new_stride)
   );

   assign hit = ent_vld && (ent_tag == tag);

   rv_judge #(
      .DATA_W(DATA_W), .GATE_ZERO_STRIDE(GATE_ZERO_STRIDE)
   ) u_judge (
      .hit(hit), .last(ent_last), .stride(ent_stride), .result(cmp_result),
      .match(match), .next_stride(new_stride)
   );

   logic        vv_q;
   rv_verdict_e verdict_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         vv_q      <= 1'b0;
         verdict_q <= RV_REEXEC;
      end else begin
         vv_q      <= cmp_valid;
         verdict_q <= (cmp_valid && match) ? RV_DROP : RV_REEXEC;
      end
   end

   assign verdict_valid = vv_q;
   assign validated     = vv_q && (verdict_q == RV_DROP);
   assign re_execute    = vv_q && (verdict_q == RV_REEXEC);
endmodule

// File: rtl/rv_checker.sv
module rv_checker #(
   parameter int PC_W             = 32,
   parameter int DATA_W           = 32,
   parameter bit GATE_ZERO_STRIDE = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              cmp_valid,
   input logic [PC_W-1:0]   cmp_pc,
   input logic [DATA_W-1:0] cmp_result,
   input logic              verdict_valid,
   input logic              validated,
   input logic              re_execute
);
   logic              prev_req;
   logic [PC_W-1:0]   prev_pc;
   logic [DATA_W-1:0] prev_res;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_req <= 1'b0;
         prev_pc  <= '0;
         prev_res <= '0;
      end else begin
         prev_req <= cmp_valid;
         prev_pc  <= cmp_pc;
         prev_res <= cmp_result;
      end
   end

   // R2
   req_gives_verdict_chk: assert property (@(posedge clk) disable iff (rst)
      cmp_valid |=> verdict_valid);

   // R2
   idle_gives_none_chk: assert property (@(posedge clk) disable iff (rst)
      !cmp_valid |=> !verdict_valid);

   // R3
   one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
      verdict_valid |-> $onehot({validated, re_execute}));

   // R3
   quiet_outputs_chk: assert property (@(posedge clk) disable iff (rst)
      !verdict_valid |-> !validated && !re_execute);

   // R7
   repeat_value_chk: assert property (@(posedge clk) disable iff (rst)
      (GATE_ZERO_STRIDE && cmp_valid && prev_req && cmp_pc == prev_pc
       && cmp_result == prev_res) |=> re_execute);
endmodule

bind result_validator rv_checker #(
   .PC_W(PC_W), .DATA_W(DATA_W), .GATE_ZERO_STRIDE(GATE_ZERO_STRIDE)
) u_rv_checker (
   .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_pc(cmp_pc),
   .cmp_result(cmp_result), .verdict_valid(verdict_valid),
   .validated(validated), .re_execute(re_execute)
);

// File: tb/result_validator_tb.sv
module result_validator_tb;
   localparam int PC_W    = 16;
   localparam int DATA_W  = 16;
   localparam int ALIGN_W = 2;
   localparam int IDX_W   = 4;
   localparam int TAG_W   = 4;
   localparam int DEPTH   = 1 << IDX_W;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              cmp_valid = 1'b0;
   logic [PC_W-1:0]   cmp_pc = '0;
   logic [DATA_W-1:0] cmp_result = '0;
   logic              verdict_valid, validated, re_execute;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   result_validator #(
      .PC_W(PC_W), .DATA_W(DATA_W), .ALIGN_W(ALIGN_W),
      .IDX_W(IDX_W), .TAG_W(TAG_W), .GATE_ZERO_STRIDE(1'b1)
   ) u_dut (
      .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_pc(cmp_pc),
      .cmp_result(cmp_result), .verdict_valid(verdict_valid),
      .validated(validated), .re_execute(re_execute)
   );

   // reference table
   bit                m_vld    [DEPTH];
   logic [TAG_W-1:0]  m_tag    [DEPTH];
   logic [DATA_W-1:0] m_last   [DEPTH];
   logic [DATA_W-1:0] m_stride [DEPTH];

   function automatic logic [PC_W-1:0] mk_pc(int tg, int ix);
      return PC_W'((tg << (ALIGN_W + IDX_W)) | (ix << ALIGN_W));
   endfunction

   function automatic logic [DATA_W-1:0] model_pred(logic [PC_W-1:0] pc);
      int ix = int'(pc[ALIGN_W +: IDX_W]);
      return m_last[ix] + m_stride[ix];
   endfunction

   task automatic check(string req, logic act, logic exp, string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
   endtask

   // one compare: drive at negedge, sample 1 ns after the capturing edge
   task automatic compare(logic [PC_W-1:0] pc, logic [DATA_W-1:0] res, string force_req);
      int               ix = int'(pc[ALIGN_W +: IDX_W]);
      logic [TAG_W-1:0] tg = pc[ALIGN_W+IDX_W +: TAG_W];
      bit               hit;
      bit               exp_ok;
      string            req;
      @(negedge clk);
      cmp_valid  = 1'b1;
      cmp_pc     = pc;
      cmp_result = res;
      hit = m_vld[ix] && (m_tag[ix] == tg);
      if (!hit) begin
         exp_ok = 1'b0; req = "R4";
         m_vld[ix] = 1'b1; m_tag[ix] = tg; m_last[ix] = res; m_stride[ix] = '0;
      end else begin
         if (m_stride[ix] == '0) begin
            exp_ok = 1'b0; req = "R7";
         end else if (DATA_W'(m_last[ix] + m_stride[ix]) == res) begin
            exp_ok = 1'b1; req = "R5";
         end else begin
            exp_ok = 1'b0; req = "R6";
         end
         m_stride[ix] = res - m_last[ix];
         m_last[ix]   = res;
      end
      if (force_req != "") req = force_req;
      @(posedge clk);
      #1;
      check("R2", verdict_valid, 1'b1, "verdict_valid");
      check(req, validated, exp_ok, "validated");
      check("R3", re_execute, !exp_ok, "re_execute");
   endtask

   task automatic idle();
      @(negedge clk);
      cmp_valid = 1'b0;
      @(posedge clk);
      #1;
      check("R2", verdict_valid, 1'b0, "idle verdict_valid");
      check("R3", validated | re_execute, 1'b0, "idle outputs");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      cmp_valid = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      check("R2", verdict_valid, 1'b0, "verdict_valid in reset");
      @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [PC_W-1:0]   pool [24];
      logic [PC_W-1:0]   pa, pb;
      process::self().srandom(32'd1234);
      void'($urandom(32'd7));
      do_reset();

      // R1: every address misses right after reset
      pa = mk_pc(3, 5);
      compare(pa, 16'd10, "R1");
      compare(pa, 16'd20, "R8");   // hit, stride becomes 10
      compare(pa, 16'd30, "R5");   // 20+10
      compare(pa, 16'd45, "R6");   // predicted 40, stride becomes 15
      compare(pa, 16'd60, "R8");   // trained stride 15 gives 60
      idle();

      // R7: repeated value gives zero stride, never validated
      pb = mk_pc(1, 9);
      compare(pb, 16'd7, "R4");
      compare(pb, 16'd7, "R7");
      compare(pb, 16'd7, "R7");
      compare(pb, 16'd8, "R6");
      compare(pb, 16'd9, "R5");

      // R10: wrap of prediction
      pa = mk_pc(2, 2);
      compare(pa, 16'hFFE0, "R4");
      compare(pa, 16'hFFF8, "R8");  // stride 0x18
      compare(pa, 16'h0010, "R10"); // 0xFFF8+0x18 wraps
      compare(pa, 16'h0028, "R10");

      // R9: alias at same index with another tag evicts
      pa = mk_pc(4, 11);
      pb = mk_pc(5, 11);
      compare(pa, 16'd100, "R4");
      compare(pa, 16'd110, "R8");
      compare(pb, 16'd120, "R9");   // tag miss
      compare(pa, 16'd120, "R9");   // evicted: miss again
      compare(mk_pc(4, 12), 16'd5, "R9"); // neighbour index is separate
      idle();

      // R1: reset drops learned entries
      compare(mk_pc(6, 1), 16'd1, "R4");
      compare(mk_pc(6, 1), 16'd2, "R8");
      do_reset();
      compare(mk_pc(6, 1), 16'd3, "R1");

      // random phase
      for (int i = 0; i < 24; i++)
         pool[i] = mk_pc(int'($urandom_range(0, 3)), int'($urandom_range(0, DEPTH - 1)));
      for (int i = 0; i < 3000; i++) begin
         logic [PC_W-1:0]   p = pool[$urandom_range(0, 23)];
         logic [DATA_W-1:0] r;
         int                sel = int'($urandom_range(0, 9));
         if (sel < 5)      r = model_pred(p);
         else if (sel < 7) r = m_last[int'(p[ALIGN_W +: IDX_W])];
         else              r = DATA_W'($urandom);
         if (sel == 9) idle();
         else compare(p, r, "");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule